// File: doc/BRIEF.md
# Raster Compare Interrupt Controller

This block raises a CPU interrupt when the video beam reaches a programmed line. It compares the current logical raster line against a 9-bit compare value held in two byte-wide registers. When the line first equals that value, it latches a pending flag. The flag is masked by an enable bit, and the result drives an active-low interrupt line to the CPU.

The CPU acknowledges the interrupt by writing a 1 to the flag's bit in the status register. Writing 0 leaves the flag alone. A read-modify-write instruction first writes back the value it read, and that value carries a 1 in every pending bit. So the dummy write of such an instruction acknowledges every pending interrupt, whatever modified value follows it.

The interrupt output has two register stages after the flag. The extra stage lets the output reach a distant CPU without squeezing timing. The CPU runs at half the pixel clock, so the added pixel clock still lands inside the same CPU cycle window.

Top module: `rstr_irq_ctrl`

## Requirements
- R1: After reset the compare value is 0 and the enable bit is 0. No flag is pending and `irq_n` is 1. Status (offset 0x19) reads 0x7E, enable (offset 0x1A) reads 0xFE, and offsets 0x11 and 0x12 read 0x00.
- R2: The compare value is 9 bits. Bits 7:0 are written and read at offset 0x12. Bit 8 is bit 7 of offset 0x11, which reads as {bit 8, 7'b0}. All 9 bits take part in the equality test against `raster_line`.
- R3: The flag sets on the first clock on which `raster_line` equals the compare value. Holding the same line afterwards does not set it again.
- R4: Bit 0 of offset 0x1A is the raster enable, and the register reads as {7'b1111111, enable}. The flag sets whether or not the enable bit is 1.
- R5: Status (offset 0x19) reads as {flag AND enable, 6'b111111, flag}. Bit 0 is the raster flag and bit 7 is the pending summary.
- R6: A write to 0x19 with bit 0 equal to 1 clears the flag. A write with bit 0 equal to 0 leaves it unchanged. Writing back the value just read clears a pending flag.
- R7: `irq_n` at each clock edge equals the inverse of (flag AND enable) two edges earlier, so assertion and release each lag by two clocks.
- R8: Writing a compare value equal to the line currently on `raster_line` sets the flag on the next clock edge.
- R9: If a new match and a clearing write occur on the same clock, the flag stays set.
- R10: Reads of any offset other than 0x11, 0x12, 0x19 and 0x1A return 0xFF.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| raster_line | input | 9 | Current logical raster line |
| reg_addr | input | 6 | Register offset for reads and writes |
| reg_wr | input | 1 | Write strobe, one clock per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_n | output | 1 | Registered active-low interrupt request |

## Verification
The line comparison is tried in several ways:
- a line that differs from the compare value only in bit 8, which separates a full 9-bit compare from an 8-bit one;
- a line held on the compare value for many clocks, which separates an edge-triggered flag from a level one;
- a compare write onto the line the beam is already on.

Acknowledge is tried with three write patterns:
- a write of 0xFE, showing that 0 bits are ignored;
- a write-back of the read value followed by 0x00, the increment idiom;
- a clear on the same clock as a fresh match.

Interrupt timing is checked at exact cycles after a match, after a clear and after an enable, which separates a two-stage output from a one-stage one.

// File: rtl/rstr_irq_pkg.sv
package rstr_irq_pkg;
  localparam int LINE_W = 9;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 6;

  // Register offsets; software depends on these positions.
  localparam logic [ADDR_W-1:0] OFS_CMP_HI = 6'h11;
  localparam logic [ADDR_W-1:0] OFS_CMP_LO = 6'h12;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 6'h19;
  localparam logic [ADDR_W-1:0] OFS_ENA    = 6'h1A;

  // Field positions
  localparam int CMP_HI_BIT = 7;  // compare bit 8 inside offset 0x11
  localparam int RST_BIT    = 0;  // raster flag / enable bit
  localparam int SUM_BIT    = 7;  // pending summary bit in status
  localparam int PAD_W      = DATA_W - 2;
endpackage

// File: rtl/rstr_cmp_regs.sv
module rstr_cmp_regs
  import rstr_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_ena,
  input  logic [DATA_W-1:0] wdata,
  output logic [LINE_W-1:0] cmp_val,
  output logic              ena
);
  logic [DATA_W-1:0] lo_q, lo_d;
  logic              hi_q, hi_d;
  logic              ena_q, ena_d;

  always_comb begin
    lo_d  = lo_q;
    hi_d  = hi_q;
    ena_d = ena_q;
    if (wr_lo)  lo_d  = wdata;
    if (wr_hi)  hi_d  = wdata[CMP_HI_BIT];
    if (wr_ena) ena_d = wdata[RST_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= 1'b0;
      ena_q <= 1'b0;
    end else begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      ena_q <= ena_d;
    end
  end

  assign cmp_val = {hi_q, lo_q};
  assign ena     = ena_q;
endmodule

// File: rtl/rstr_match_det.sv
module rstr_match_det
  import rstr_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line,
  input  logic [LINE_W-1:0] cmp_val,
  output logic              rise
);
  logic hit, hit_q;

  assign hit = (line == cmp_val);

  // Reset to "already matching" so release of reset never fakes an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b1;
    else        hit_q <= hit;
  end

  assign rise = hit & ~hit_q;
endmodule

// File: rtl/rstr_irq_status.sv
module rstr_irq_status (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic clr_req,
  input  logic ena,
  output logic flag,
  output logic pend,
  output logic irq_n
);
  logic flag_q, flag_d;
  logic stage_q;
  logic irq_n_q;

  // A new event outranks a simultaneous acknowledge.
  always_comb begin
    flag_d = flag_q;
    if (clr_req) flag_d = 1'b0;
    if (rise)    flag_d = 1'b1;
  end

  assign pend = flag_q & ena;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      stage_q <= 1'b0;
      irq_n_q <= 1'b1;
    end else begin
      flag_q  <= flag_d;
      stage_q <= pend;
      irq_n_q <= ~stage_q;
    end
  end

  assign flag  = flag_q;
  assign irq_n = irq_n_q;
endmodule

// File: rtl/rstr_irq_ctrl.sv
module rstr_irq_ctrl
  import rstr_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] raster_line,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_n
);
  logic              wr_lo, wr_hi, wr_ena, clr_req;
  logic [LINE_W-1:0] cmp_val;
  logic              ena, rise, flag, pend;

  assign wr_lo   = reg_wr && (reg_addr == OFS_CMP_LO);
  assign wr_hi   = reg_wr && (reg_addr == OFS_CMP_HI);
  assign wr_ena  = reg_wr && (reg_addr == OFS_ENA);
  assign clr_req = reg_wr && (reg_addr == OFS_STAT) && reg_wdata[RST_BIT];

  rstr_cmp_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_lo  (wr_lo),
    .wr_hi  (wr_hi),
    .wr_ena (wr_ena),
    .wdata  (reg_wdata),
    .cmp_val(cmp_val),
    .ena    (ena)
  );

  rstr_match_det u_match (
    .clk    (clk),
    .rst_n  (rst_n),
    .line   (raster_line),
    .cmp_val(cmp_val),
    .rise   (rise)
  );

  rstr_irq_status u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise   (rise),
    .clr_req(clr_req),
    .ena    (ena),
    .flag   (flag),
    .pend   (pend),
    .irq_n  (irq_n)
  );

  always_comb begin
    case (reg_addr)
      OFS_CMP_HI: reg_rdata = {cmp_val[LINE_W-1], {(DATA_W-1){1'b0}}};
      OFS_CMP_LO: reg_rdata = cmp_val[DATA_W-1:0];
      OFS_STAT:   reg_rdata = {pend, {PAD_W{1'b1}}, flag};
      OFS_ENA:    reg_rdata = {{(DATA_W-1){1'b1}}, ena};
      default:    reg_rdata = {DATA_W{1'b1}};
    endcase
  end
endmodule

// File: rtl/rstr_irq_chk.sv
module rstr_irq_chk
  import rstr_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rise,
  input logic              clr_req,
  input logic              flag,
  input logic              pend,
  input logic              irq_n,
  input logic              wr_lo,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [LINE_W-1:0] cmp_val
);
  // R7
  irq_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> ##2 !irq_n);

  // R7
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |-> ##2 irq_n);

  // R3 R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> flag);

  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !rise) |=> !flag);

  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !rise) |=> !flag);

  // R3
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

  // R2
  cmp_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (cmp_val[DATA_W-1:0] == $past(reg_wdata)));
endmodule

bind rstr_irq_ctrl rstr_irq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rise     (rise),
  .clr_req  (clr_req),
  .flag     (flag),
  .pend     (pend),
  .irq_n    (irq_n),
  .wr_lo    (wr_lo),
  .reg_wdata(reg_wdata),
  .cmp_val  (cmp_val)
);

// File: tb/rstr_irq_ctrl_tb.sv
`timescale 1ns/1ps
module rstr_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] raster_line = 9'd50;
  logic [5:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_n;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int         due;
    bit         is_rd;
    logic [7:0] exp;
    string      tag;
  } exp_t;
  exp_t sbq[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rstr_irq_ctrl u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .raster_line(raster_line),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .irq_n      (irq_n)
  );

  // Monitor: compare every expectation falling due in this cycle.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = sbq.size() - 1; i >= 0; i--) begin
        if (sbq[i].due == cyc) begin
          logic [7:0] act;
          act = sbq[i].is_rd ? reg_rdata : {7'b0, irq_n};
          total++;
          if (act !== sbq[i].exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h cycle=%0d", sbq[i].tag,
                     sbq[i].is_rd ? "rdata" : "irq_n", act, sbq[i].exp, cyc);
          end
          sbq.delete(i);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(input int dly, input bit is_rd, input logic [7:0] e, input string tag);
    exp_t it;
    it.due = cyc + dly; it.is_rd = is_rd; it.exp = e; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic rd(input logic [5:0] a, input logic [7:0] e, input string tag);
    reg_addr = a;
    push(0, 1'b1, e, tag);
    tick(1);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic irq_exp(input int dly, input bit v, input string tag);
    push(dly, 1'b0, {7'b0, v}, tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    irq_exp(0, 1'b1, "R1");
    rd(6'h19, 8'h7E, "R1");
    rd(6'h1A, 8'hFE, "R1");
    rd(6'h12, 8'h00, "R1");
    rd(6'h11, 8'h00, "R1");
    rd(6'h20, 8'hFF, "R10");
    // R2 compare split across two offsets
    wr(6'h11, 8'h80);
    wr(6'h12, 8'h23);
    rd(6'h11, 8'h80, "R2");
    rd(6'h12, 8'h23, "R2");
    // R4 flag sets with enable off; irq stays high
    raster_line = 9'h123;
    irq_exp(2, 1'b1, "R4"); irq_exp(3, 1'b1, "R4"); irq_exp(4, 1'b1, "R4");
    tick(5);
    rd(6'h19, 8'h7F, "R4");
    // R7 enabling a pending flag drives irq two clocks later
    wr(6'h1A, 8'h01);
    irq_exp(1, 1'b1, "R7"); irq_exp(2, 1'b0, "R7");
    rd(6'h1A, 8'hFF, "R4");
    tick(3);
    rd(6'h19, 8'hFF, "R5");
    // R6 clear by writing 1, release two clocks later (R7)
    wr(6'h19, 8'h01);
    irq_exp(1, 1'b0, "R7"); irq_exp(2, 1'b1, "R7");
    rd(6'h19, 8'h7E, "R6");
    // R3 line held: no second set
    tick(4);
    rd(6'h19, 8'h7E, "R3");
    // R3 R7 new match: irq low three clocks after line change
    raster_line = 9'h122;
    tick(2);
    raster_line = 9'h123;
    irq_exp(2, 1'b1, "R7"); irq_exp(3, 1'b0, "R7");
    tick(5);
    rd(6'h19, 8'hFF, "R3");
    // R6 write of 0 in bit 0 ignored
    wr(6'h19, 8'hFE);
    rd(6'h19, 8'hFF, "R6");
    irq_exp(1, 1'b0, "R6");
    tick(3);
    // R6 increment idiom: write back read value, then modified value
    wr(6'h19, 8'hFF);
    wr(6'h19, 8'h00);
    rd(6'h19, 8'h7E, "R6");
    tick(3);
    irq_exp(0, 1'b1, "R6");
    tick(1);
    // R9 match and clear on the same clock
    raster_line = 9'h122;
    tick(2);
    raster_line = 9'h123;
    tick(2);
    raster_line = 9'h122;
    tick(2);
    rd(6'h19, 8'hFF, "R9");
    raster_line = 9'h123;
    wr(6'h19, 8'h01);
    rd(6'h19, 8'hFF, "R9");
    wr(6'h19, 8'h01);
    rd(6'h19, 8'h7E, "R9");
    tick(3);
    // R8 compare written onto the current line
    raster_line = 9'h040;
    tick(1);
    wr(6'h11, 8'h00);
    wr(6'h12, 8'h40);
    irq_exp(2, 1'b1, "R8"); irq_exp(3, 1'b0, "R8");
    rd(6'h19, 8'h7E, "R8");
    rd(6'h19, 8'hFF, "R8");
    wr(6'h19, 8'h01);
    tick(3);
    // R2 bit 8 takes part in the compare
    raster_line = 9'h140;
    tick(3);
    rd(6'h19, 8'h7E, "R2");
    wr(6'h11, 8'h80);
    tick(1);
    rd(6'h19, 8'hFF, "R2");
    tick(5);
    foreach (sbq[i]) begin
      total++; bad++;
      $display("FAIL %s unchecked actual=missed expected=%h", sbq[i].tag, sbq[i].exp);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule